// File: doc/BRIEF.md
# MDIO Station Management Master

This block is the station side of a two-wire management bus. It generates the management clock (MDC) from the system clock and runs one complete read or write frame for each accepted command, talking to the PHYs that share the bidirectional data line (MDIO). The pad is outside the block. The block presents MDIO as an output value, an output enable and a sampled input, and the board pull-up supplies a logic 1 whenever nobody drives the line.

A command is accepted on a `cmd_start` pulse while `busy` is low. The command carries a read/write select, a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data. `busy` covers the whole frame. `done` pulses for one system clock when the frame ends. On a read, `rd_data` and `no_resp` are valid from the `done` cycle until the next command is accepted. `no_resp` reports that no PHY pulled the second turnaround bit low.

MDC runs only while a frame is in progress and is held low at every other time. After reset the block waits one full MDC period with the bus quiet before it accepts its first command.

Top module: `mdio_master`

## Requirements
- R1: From reset until 2·H system clock edges after reset release, `busy` is high and MDC is low. Any `cmd_start` in this window is discarded, so no frame runs and no `done` follows.
- R2: The MDC half period H is the larger of `div_half` and ceil(CLK_HZ / (2·MDC_MAX_HZ)), counted in system clocks. The value is captured when a command is accepted. With the default parameters H is never below 2, which limits MDC to 25 MHz.
- R3: A frame has 32 bits, sent MSB first. Two start bits 0,1 come first, then the opcode (1,0 = read, 0,1 = write), then the PHY address and the register address (5 bits each), two turnaround bits and 16 data bits. Each bit is set up at the MDC falling edge (at acceptance for the first bit) and stays stable across the following MDC rising edge.
- R4: On a write the master drives MDIO for all 32 bits. The turnaround bits are 1 then 0, and the data bits are `cmd_wdata`, most significant bit first.
- R5: On a read, `mdio_oe` is low for the last 18 bits of the frame (both turnaround bits and all data bits). `rd_data` holds the 16 values of `mdio_i` sampled at the data-bit MDC rising edges, the first sample in bit 15.
- R6: `no_resp` is 1 after a read in which `mdio_i` was 1 at the rising edge of the second turnaround bit. It is 0 after any other read and after every write.
- R7: `busy` is high from the clock after acceptance until the frame ends. `done` is a single-clock pulse exactly 64·H clocks after the accepting edge, and `busy` is already low in that cycle.
- R8: A `cmd_start` arriving while `busy` is high has no effect. The running frame, its timing and its results do not change, and no extra frame follows.
- R9: While `busy` is low, MDC is low and `mdio_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_half | input | DIV_W | Requested MDC half period in system clocks |
| cmd_start | input | 1 | Command request, taken when `busy` is low |
| cmd_read | input | 1 | 1 = read frame, 0 = write frame |
| cmd_phy | input | 5 | PHY address |
| cmd_reg | input | 5 | Register address |
| cmd_wdata | input | 16 | Write data |
| busy | output | 1 | Frame or post-reset quiet period in progress |
| done | output | 1 | One-clock end-of-frame pulse |
| rd_data | output | 16 | Data captured by the last read |
| no_resp | output | 1 | Last read saw no turnaround zero |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value to drive |
| mdio_oe | output | 1 | MDIO drive enable |
| mdio_i | input | 1 | MDIO value seen at the pad |

## Verification
Take the accepting edge as cycle 0. MDC first rises H clocks later, each bit then lasts 2·H clocks, and `done` appears 64·H clocks later. The post-reset quiet period ends 2·H edges after release. The bench stamps each accepted command with the cycle count, read at the falling edge of the system clock after acceptance. The scoreboard then expects `done` exactly 64·H counts later and compares `rd_data`, `no_resp`, the captured frame and the measured MDC period at that point. The bench PHY model drives `mdio_i` on MDC falling edges, so every value is settled H clocks before the rising edge that samples it.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int unsigned PHY_W    = 5;
  localparam int unsigned REG_W    = 5;
  localparam int unsigned DATA_W   = 16;
  localparam int unsigned FRAME_W  = 2 + 2 + PHY_W + REG_W + 2 + DATA_W;
  localparam int unsigned IDX_W    = $clog2(FRAME_W);
  // bit index (counting down to 0) of the two turnaround slots
  localparam int unsigned TA_FIRST = DATA_W + 1;
  localparam int unsigned TA_LAST  = DATA_W;

  typedef enum logic [1:0] {
    SEQ_GUARD = 2'd0,
    SEQ_IDLE  = 2'd1,
    SEQ_RUN   = 2'd2
  } seq_state_e;

  // Whole outgoing frame, first bit in the MSB.
  function automatic logic [FRAME_W-1:0] frame_word(
    input logic              is_read,
    input logic [PHY_W-1:0]  phy,
    input logic [REG_W-1:0]  rg,
    input logic [DATA_W-1:0] wd
  );
    logic [1:0]        op;
    logic [1:0]        ta;
    logic [DATA_W-1:0] d;
    op = is_read ? 2'b10 : 2'b01;
    ta = is_read ? 2'b11 : 2'b10;
    d  = is_read ? '0 : wd;
    return {2'b01, op, phy, rg, ta, d};
  endfunction

  // Smallest half period (system clocks) that keeps MDC at or below max_hz.
  function automatic int unsigned min_half(
    input int unsigned clk_hz,
    input int unsigned max_hz
  );
    logic [63:0] den;
    logic [63:0] q;
    den = 64'(max_hz) * 64'd2;
    q   = (64'(clk_hz) + den - 64'd1) / den;
    if (q == 64'd0) q = 64'd1;
    return 32'(q);
  endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half,
  output logic             mdc,
  output logic             rise_evt,
  output logic             fall_evt
);

  logic [DIV_W-1:0] cnt_q;
  logic             wrap;

  assign wrap     = run && (cnt_q == half - DIV_W'(1));
  assign rise_evt = wrap && !mdc;
  assign fall_evt = wrap && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc   <= 1'b0;
    end else if (!run) begin
      cnt_q <= '0;
      mdc   <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc   <= ~mdc;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  half_req,
  input  logic              cmd_start,
  input  logic              cmd_read,
  input  logic [PHY_W-1:0]  cmd_phy,
  input  logic [REG_W-1:0]  cmd_reg,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic              fall_evt,
  output logic              run,
  output logic              busy,
  output logic              accept,
  output logic              done,
  output logic              is_read,
  output logic [IDX_W-1:0]  bit_idx,
  output logic [DIV_W-1:0]  half_q,
  output logic              mdio_o,
  output logic              mdio_oe
);

  seq_state_e         st_q;
  logic [DIV_W:0]     gcnt_q;
  logic [DIV_W:0]     guard_last;
  logic               guard_end;
  logic               last_fall;
  logic               in_release;
  logic [FRAME_W-1:0] sh_q;

  assign guard_last = {half_req, 1'b0} - (DIV_W+1)'(1);
  assign guard_end  = (st_q == SEQ_GUARD) && (gcnt_q == guard_last);
  assign accept     = (st_q == SEQ_IDLE) && cmd_start;
  assign run        = (st_q == SEQ_RUN);
  assign busy       = (st_q != SEQ_IDLE);
  assign last_fall  = run && fall_evt && (bit_idx == '0);
  assign in_release = is_read && (bit_idx <= IDX_W'(TA_FIRST));

  assign mdio_o  = run && sh_q[FRAME_W-1];
  assign mdio_oe = run && !in_release;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SEQ_GUARD;
      gcnt_q  <= '0;
      sh_q    <= '0;
      bit_idx <= '0;
      is_read <= 1'b0;
      half_q  <= '0;
      done    <= 1'b0;
    end else begin
      done <= last_fall;
      case (st_q)
        SEQ_GUARD: begin
          if (guard_end) st_q <= SEQ_IDLE;
          else           gcnt_q <= gcnt_q + (DIV_W+1)'(1);
        end
        SEQ_IDLE: begin
          if (cmd_start) begin
            st_q    <= SEQ_RUN;
            sh_q    <= frame_word(cmd_read, cmd_phy, cmd_reg, cmd_wdata);
            bit_idx <= IDX_W'(FRAME_W - 1);
            is_read <= cmd_read;
            half_q  <= half_req;
          end
        end
        SEQ_RUN: begin
          if (fall_evt) begin
            if (bit_idx == '0) begin
              st_q <= SEQ_IDLE;
            end else begin
              bit_idx <= bit_idx - IDX_W'(1);
              sh_q    <= {sh_q[FRAME_W-2:0], 1'b0};
            end
          end
        end
        default: st_q <= SEQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mdio_rx_capture.sv
module mdio_rx_capture
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              rise_evt,
  input  logic              is_read,
  input  logic [IDX_W-1:0]  bit_idx,
  input  logic              mdio_i,
  output logic [DATA_W-1:0] rd_data,
  output logic              no_resp
);

  logic at_ta2;
  logic at_data;

  assign at_ta2  = (bit_idx == IDX_W'(TA_LAST));
  assign at_data = (bit_idx <  IDX_W'(TA_LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      no_resp <= 1'b0;
    end else if (clear) begin
      rd_data <= '0;
      no_resp <= 1'b0;
    end else if (rise_evt && is_read) begin
      if (at_ta2)       no_resp <= mdio_i;
      else if (at_data) rd_data <= {rd_data[DATA_W-2:0], mdio_i};
    end
  end

endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int unsigned DIV_W      = 8,
  parameter int unsigned CLK_HZ     = 100_000_000,
  parameter int unsigned MDC_MAX_HZ = 25_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div_half,
  input  logic              cmd_start,
  input  logic              cmd_read,
  input  logic [PHY_W-1:0]  cmd_phy,
  input  logic [REG_W-1:0]  cmd_reg,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic              no_resp,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);

  localparam int unsigned      MIN_HALF   = min_half(CLK_HZ, MDC_MAX_HZ);
  localparam logic [DIV_W-1:0] MIN_HALF_V = DIV_W'(MIN_HALF);

  logic [DIV_W-1:0] half_eff;
  logic [DIV_W-1:0] half_run;
  logic             seq_run;
  logic             seq_accept;
  logic             seq_is_read;
  logic [IDX_W-1:0] seq_idx;
  logic             mdc_rise;
  logic             mdc_fall;

  assign half_eff = (div_half < MIN_HALF_V) ? MIN_HALF_V : div_half;

  mdio_frame_seq #(.DIV_W(DIV_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .half_req  (half_eff),
    .cmd_start (cmd_start),
    .cmd_read  (cmd_read),
    .cmd_phy   (cmd_phy),
    .cmd_reg   (cmd_reg),
    .cmd_wdata (cmd_wdata),
    .fall_evt  (mdc_fall),
    .run       (seq_run),
    .busy      (busy),
    .accept    (seq_accept),
    .done      (done),
    .is_read   (seq_is_read),
    .bit_idx   (seq_idx),
    .half_q    (half_run),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe)
  );

  mdio_mdc_gen #(.DIV_W(DIV_W)) u_mdc (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (seq_run),
    .half     (half_run),
    .mdc      (mdc),
    .rise_evt (mdc_rise),
    .fall_evt (mdc_fall)
  );

  mdio_rx_capture u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (seq_accept),
    .rise_evt (mdc_rise),
    .is_read  (seq_is_read),
    .bit_idx  (seq_idx),
    .mdio_i   (mdio_i),
    .rd_data  (rd_data),
    .no_resp  (no_resp)
  );

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int unsigned FRAME_W = 32
) (
  input logic clk,
  input logic rst_n,
  input logic cmd_start,
  input logic cmd_read,
  input logic busy,
  input logic done,
  input logic no_resp,
  input logic mdc,
  input logic mdio_o,
  input logic mdio_oe,
  input logic accept,
  input logic rise_evt
);

  logic [7:0] rises_q;
  logic       rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rises_q <= '0;
      rd_q    <= 1'b0;
    end else if (accept) begin
      rises_q <= '0;
      rd_q    <= cmd_read;
    end else if (rise_evt) begin
      rises_q <= rises_q + 8'd1;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe)); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R7
  AST_ACCEPT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (!busy && cmd_start)); // R8
  AST_ACCEPT_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy && mdio_oe)); // R3
  AST_STABLE_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |-> ($stable(mdio_o) && $stable(mdio_oe))); // R3
  AST_FULL_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rises_q == 8'(FRAME_W))); // R3
  AST_WRITE_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !rd_q) |-> !no_resp); // R6
  AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && !rd_q) |-> mdio_oe); // R4

endmodule

bind mdio_master mdio_master_chk #(.FRAME_W(mdio_pkg::FRAME_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_start (cmd_start),
  .cmd_read  (cmd_read),
  .busy      (busy),
  .done      (done),
  .no_resp   (no_resp),
  .mdc       (mdc),
  .mdio_o    (mdio_o),
  .mdio_oe   (mdio_oe),
  .accept    (seq_accept),
  .rise_evt  (mdc_rise)
);

// File: tb/mdio_master_test.sv
module mdio_master_test;

  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] MY_PHY = 5'd9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  div_half = 8'd0;
  logic        cmd_start = 1'b0;
  logic        cmd_read = 1'b0;
  logic [4:0]  cmd_phy = '0;
  logic [4:0]  cmd_reg = '0;
  logic [15:0] cmd_wdata = '0;
  logic        busy, done, no_resp, mdc, mdio_o, mdio_oe;
  logic [15:0] rd_data;
  logic        mdio_i = 1'b1;

  mdio_master uut (
    .clk(clk), .rst_n(rst_n), .div_half(div_half), .cmd_start(cmd_start),
    .cmd_read(cmd_read), .cmd_phy(cmd_phy), .cmd_reg(cmd_reg),
    .cmd_wdata(cmd_wdata), .busy(busy), .done(done), .rd_data(rd_data),
    .no_resp(no_resp), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_tests = 0;
  int n_fail = 0;
  bit ended = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // ---------------- PHY model ----------------
  logic [15:0] phy_rf [32];
  logic [15:0] mirror [32];
  int          nbit = 0;
  int          n_rel = 0;
  logic [31:0] rxw = '0;
  bit          resp = 0;
  logic [15:0] tx = '0;
  int          rise_c0 = 0;
  int          rise_c1 = 0;

  initial begin
    for (int i = 0; i < 32; i++) begin
      phy_rf[i] = 16'(i * 273) ^ 16'hA500;
      mirror[i] = 16'(i * 273) ^ 16'hA500;
    end
  end

  always @(posedge busy) begin
    nbit = 0; n_rel = 0; rxw = '0;
  end

  always @(posedge mdc) begin
    rxw = {rxw[30:0], mdio_oe ? mdio_o : 1'b1};
    if (!mdio_oe) n_rel++;
    if (nbit == 0) rise_c0 = cyc;
    if (nbit == 1) rise_c1 = cyc;
    nbit++;
    if (nbit == 32 && rxw[29:28] == 2'b01 && rxw[27:23] == MY_PHY)
      phy_rf[rxw[22:18]] = rxw[15:0];
  end

  always @(negedge mdc) begin
    if (nbit == 15 && rxw[12:11] == 2'b10 && rxw[10:6] == MY_PHY) begin
      resp = 1; tx = phy_rf[rxw[5:1]]; mdio_i = 1'b0;
    end else if (resp && nbit >= 16 && nbit < 32) begin
      mdio_i = tx[31 - nbit];
    end else begin
      mdio_i = 1'b1;
      if (nbit >= 32) resp = 0;
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    bit          rd;
    logic [4:0]  phy;
    logic [4:0]  rg;
    logic [15:0] wd;
    logic [15:0] exp_rd;
    bit          exp_nr;
    int          acc;
    int          h;
  } item_t;

  item_t q[$];

  task automatic issue(input bit rd, input logic [4:0] phy, input logic [4:0] rg,
                       input logic [15:0] wd, input logic [7:0] div);
    item_t it;
    @(negedge clk);
    div_half = div; cmd_read = rd; cmd_phy = phy; cmd_reg = rg; cmd_wdata = wd;
    cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    check(busy === 1'b1, "R7 busy after accept", busy, 1);
    it.rd = rd; it.phy = phy; it.rg = rg; it.wd = wd;
    it.acc = cyc;
    it.h = (div < 8'd2) ? 2 : int'(div);
    if (rd && phy == MY_PHY) begin it.exp_rd = mirror[rg]; it.exp_nr = 0; end
    else if (rd)             begin it.exp_rd = 16'hFFFF;   it.exp_nr = 1; end
    else                     begin it.exp_rd = 16'h0000;   it.exp_nr = 0; end
    if (!rd && phy == MY_PHY) mirror[rg] = wd;
    q.push_back(it);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  always @(negedge clk) begin : monitor
    item_t it;
    if (rst_n && done) begin
      if (q.size() == 0) begin
        check(0, "R8 unexpected done", 1, 0);
      end else begin
        it = q.pop_front();
        check(cyc == it.acc + 64 * it.h, "R7 done cycle", cyc, it.acc + 64 * it.h);
        check(!busy, "R7 busy low with done", busy, 0);
        check(rise_c1 - rise_c0 == 2 * it.h, "R2 MDC period", rise_c1 - rise_c0, 2 * it.h);
        check(no_resp == it.exp_nr, "R6 no_resp", no_resp, it.exp_nr);
        if (it.rd) begin
          check(rd_data == it.exp_rd, "R5 rd_data", rd_data, it.exp_rd);
          check(rxw[31:18] == {2'b01, 2'b10, it.phy, it.rg}, "R3 read header",
                rxw[31:18], {2'b01, 2'b10, it.phy, it.rg});
          check(n_rel == 18, "R5 released bits", n_rel, 18);
        end else begin
          check(rxw == {2'b01, 2'b01, it.phy, it.rg, 2'b10, it.wd}, "R4 write frame",
                rxw, {2'b01, 2'b01, it.phy, it.rg, 2'b10, it.wd});
        end
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin : stimulus
    bit quiet;
    repeat (3) @(negedge clk);
    check(mdc == 1'b0 && mdio_oe == 1'b0 && done == 1'b0, "R9 reset outputs",
          {mdc, mdio_oe, done}, 0);
    // R1: quiet period of 2*H edges with H = 2, start held and ignored
    rst_n = 1'b1; cmd_start = 1'b1; cmd_read = 1'b0; cmd_phy = MY_PHY;
    quiet = 1;
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      if (!(busy && !mdc && !mdio_oe)) quiet = 0;
    end
    cmd_start = 1'b0;
    check(quiet, "R1 busy high, bus quiet after reset", quiet, 1);
    @(negedge clk);
    check(busy == 1'b0, "R1 quiet period ends after 2H edges", busy, 0);
    quiet = 1;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (busy || mdc || done) quiet = 0;
    end
    check(quiet, "R1 start during quiet period dropped", quiet, 1);

    issue(0, MY_PHY, 5'd3, 16'hBEEF, 8'd0);   wait_idle();
    issue(1, MY_PHY, 5'd3, 16'h0000, 8'd0);   wait_idle();
    issue(1, MY_PHY, 5'd30, 16'h0000, 8'd5);  wait_idle();
    issue(1, 5'd4, 5'd7, 16'h0000, 8'd0);     wait_idle();   // R6 absent PHY
    issue(1, MY_PHY, 5'd0, 16'h0000, 8'd1);   wait_idle();   // R2 clamp

    // R8: write at H=3, then a competing start and divider change mid-frame
    issue(0, MY_PHY, 5'd17, 16'h1234, 8'd3);
    repeat (20) @(negedge clk);
    div_half = 8'd9; cmd_read = 1'b1; cmd_phy = 5'd1; cmd_reg = 5'd2; cmd_wdata = 16'hFFFF;
    cmd_start = 1'b1;
    repeat (3) @(negedge clk);
    cmd_start = 1'b0;
    wait_idle();
    quiet = 1;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (busy || mdc || mdio_oe) quiet = 0;
    end
    check(quiet, "R8 no frame from start while busy", quiet, 1);
    check(quiet, "R9 idle bus stays quiet", quiet, 1);

    issue(0, 5'd2, 5'd17, 16'h5555, 8'd2);    wait_idle();   // other PHY
    issue(1, MY_PHY, 5'd17, 16'h0000, 8'd2);  wait_idle();
    issue(0, MY_PHY, 5'd31, 16'h8001, 8'd0);  wait_idle();
    issue(1, MY_PHY, 5'd31, 16'h0000, 8'd0);  wait_idle();

    repeat (10) @(negedge clk);
    check(q.size() == 0, "R7 every command completed", q.size(), 0);
    finish_run();
  end

endmodule